// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-port synchronous memory whose read path has no output register. An access begins when one of two address strobes is sampled active. One strobe is meant for a processor and the other for a controller. On that edge the word address is loaded and the block is either selected or deselected, depending on three chip enables. Later cycles can step a 2-bit beat counter with an advance input. The counter supplies the two low address bits, in linear order or in interleaved order. Data out comes straight from the array at the registered address during the cycle after the edge, so it is flow-through.

Writes happen on the clock edge. A global write enable writes the whole word. A byte write enable, together with per-lane selects, writes only the chosen 9-bit lanes. The output enable is asynchronous. A read that follows a deselected state has its first cycle of output suppressed. A sleep input freezes the block and keeps the array contents intact. The tri-state data pins are replaced by separate write-data and read-data buses, plus an output-valid flag. When the outputs are disabled, read data is driven to zero.

Top module: `fts_burst_sram`

## Requirements
- R1: An edge with the controller strobe low (`strobe_ctl_n`=0) and all chip enables active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) loads `addr_i` and clears the beat counter. The next cycle reads the word at `addr_i`.
- R2: When the processor strobe is low together with `cs1_n`=0, that edge is a processor start and takes priority over the controller strobe. A processor start never writes, whatever the write enables are. When `cs1_n`=1, the processor strobe is ignored.
- R3: `cs2` and `cs3_n` are examined only on a start edge. On an edge with no start, a selected block stays selected whatever those two inputs are.
- R4: A start edge with any chip enable inactive deselects the block. While deselected, and from reset, `rdata_en_o`=0 and no write takes place.
- R5: With `order_il`=0, the two low address bits step base+1, base+2, base+3 and back to base (modulo 4) on successive edges with `adv_n`=0.
- R6: With `order_il`=1, the two low address bits equal base XOR n, where n is the count of advance edges modulo 4.
- R7: On a non-start edge with `adv_n`=1, the address holds.
- R8: `gwr_n`=0 writes all four lanes, whatever `bwr_n` and `lane_sel_n` are.
- R9: With `gwr_n`=1 and `bwr_n`=0, lane i (bits 9i+8..9i) is written exactly when `lane_sel_n[i]`=0. With `gwr_n`=1 and `bwr_n`=1, nothing is written.
- R10: The write target is the address in force after the edge. In the cycle after a non-writing selected edge, `rdata_o` equals the array word at the registered address, with no extra latency. In the cycle after a writing edge, `rdata_en_o`=0.
- R11: `oe_n`=1 forces `rdata_en_o`=0 and `rdata_o`=0 in the same cycle, with no clock involved.
- R12: In the first cycle after a start that selects the block from a deselected state, `rdata_en_o`=0 even with `oe_n`=0.
- R13: While `sleep_i`=1, the outputs are disabled, no write occurs and no state changes. Operation resumes on the first edge after release, with the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset of control state, active low |
| addr_i | input | ADDR_W | Word address |
| cs1_n | input | 1 | Chip enable 1, active low |
| cs2 | input | 1 | Chip enable 2, active high |
| cs3_n | input | 1 | Chip enable 3, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| gwr_n | input | 1 | Global write enable, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved (tie high by default) |
| sleep_i | input | 1 | Sleep request, active high |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when disabled |
| rdata_en_o | output | 1 | Read data valid (output enabled) |

## Verification
The bench builds the block with ADDR_W=6 and four 9-bit lanes. This gives a 64-word array that a directed preload fills completely, so every random read compares against a known word. The small address space makes random starts fall often into every 4-word beat group, so both orders wrap at each starting offset. It also makes random processor, controller and deselect starts meet active bursts, sleep cycles and partial-lane writes within a few thousand cycles.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
   localparam int BURST_W = 2;
   typedef logic [BURST_W-1:0] beat_t;

   // low address bits for a beat: sum for linear order, xor for interleaved
   function automatic beat_t beat_low(input beat_t first, input beat_t step,
                                      input logic interleave);
      beat_t r;
      if (interleave) r = first ^ step;
      else            r = first + step;
      return r;
   endfunction
endpackage

// File: rtl/fts_addr_ctrl.sv
`timescale 1ns/1ps
module fts_addr_ctrl
   import fts_pkg::*;
#(
   parameter int ADDR_W = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              order_il,
   input  logic              sleep_i,
   input  logic              wr_req_i,
   output logic              wr_fire_o,
   output logic [ADDR_W-1:0] next_addr_o,
   output logic [ADDR_W-1:0] cur_addr_o,
   output beat_t             cnt_o,
   output logic              active_o,
   output logic              mask_o,
   output logic              rd_o
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0] base_q, base_d;
   beat_t             cnt_q, cnt_d;
   logic              act_q, act_d;
   logic              mask_q, mask_d;
   logic              rd_q, rd_d;
   logic              cpu_start, ctl_start, start, sel;

   // processor strobe qualified by enable 1 wins over the controller strobe
   assign cpu_start = !strobe_cpu_n && !cs1_n;
   assign ctl_start = !strobe_ctl_n && !cpu_start;
   assign start     = cpu_start || ctl_start;
   assign sel       = !cs1_n && cs2 && !cs3_n;

   always_comb begin
      base_d = base_q;
      cnt_d  = cnt_q;
      act_d  = act_q;
      if (start) begin
         act_d = sel;
         if (sel) begin
            base_d = addr_i;
            cnt_d  = '0;
         end
      end else if (act_q && !adv_n) begin
         cnt_d = cnt_q + beat_t'(1);
      end
   end

   assign wr_fire_o = !sleep_i && act_d && !cpu_start && wr_req_i;
   assign mask_d    = start && sel && !act_q;
   assign rd_d      = act_d && !wr_fire_o;

   assign next_addr_o = {base_d[ADDR_W-1:BURST_W],
                         beat_low(base_d[BURST_W-1:0], cnt_d, order_il)};
   assign cur_addr_o  = {base_q[ADDR_W-1:BURST_W],
                         beat_low(base_q[BURST_W-1:0], cnt_q, order_il)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
         mask_q <= 1'b0;
         rd_q   <= 1'b0;
      end else if (!sleep_i) begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
         act_q  <= act_d;
         mask_q <= mask_d;
         rd_q   <= rd_d;
      end
   end

   assign cnt_o    = cnt_q;
   assign active_o = act_q;
   assign mask_o   = mask_q;
   assign rd_o     = rd_q;

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("fts_addr_ctrl: ADDR_W must exceed the beat field");
      end
   endgenerate
endmodule

// File: rtl/fts_wr_decode.sv
`timescale 1ns/1ps
module fts_wr_decode #(
   parameter int LANES = 4
)(
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_we_o,
   output logic             wr_req_o
);
   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         // global write overrides; otherwise a lane needs byte enable and its select
         assign lane_we_o[g] = !gwr_n || (!bwr_n && !lane_sel_n[g]);
      end
   endgenerate

   assign wr_req_o = |lane_we_o;
endmodule

// File: rtl/fts_array.sv
`timescale 1ns/1ps
module fts_array #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    we_i,
   input  logic [LANES-1:0]        lane_we_i,
   input  logic [ADDR_W-1:0]       waddr_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0]       raddr_i,
   output logic [LANES*LANE_W-1:0] rdata_o
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = LANES * LANE_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane_we_i[l])
               mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
         end
      end
   end

   // flow-through: no register between the array and the output
   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fts_burst_sram.sv
`timescale 1ns/1ps
module fts_burst_sram
   import fts_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    strobe_cpu_n,
   input  logic                    strobe_ctl_n,
   input  logic                    adv_n,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    oe_n,
   input  logic                    order_il,
   input  logic                    sleep_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   output logic [LANES*LANE_W-1:0] rdata_o,
   output logic                    rdata_en_o
);
   localparam int DATA_W = LANES * LANE_W;

   logic [LANES-1:0]  lane_we;
   logic              wr_req, wr_fire;
   logic [ADDR_W-1:0] next_addr, cur_addr;
   beat_t             burst_cnt;
   logic              ctl_active, ctl_mask, ctl_rd;
   logic [DATA_W-1:0] arr_rdata;

   generate
      if (ADDR_W < 3) begin : g_chk_addr
         $error("fts_burst_sram: ADDR_W must be at least 3");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_chk_lane
         $error("fts_burst_sram: LANES and LANE_W must be positive");
      end
   endgenerate

   fts_wr_decode #(.LANES(LANES)) u_wr_decode (
      .gwr_n      (gwr_n),
      .bwr_n      (bwr_n),
      .lane_sel_n (lane_sel_n),
      .lane_we_o  (lane_we),
      .wr_req_o   (wr_req)
   );

   fts_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_i       (addr_i),
      .cs1_n        (cs1_n),
      .cs2          (cs2),
      .cs3_n        (cs3_n),
      .strobe_cpu_n (strobe_cpu_n),
      .strobe_ctl_n (strobe_ctl_n),
      .adv_n        (adv_n),
      .order_il     (order_il),
      .sleep_i      (sleep_i),
      .wr_req_i     (wr_req),
      .wr_fire_o    (wr_fire),
      .next_addr_o  (next_addr),
      .cur_addr_o   (cur_addr),
      .cnt_o        (burst_cnt),
      .active_o     (ctl_active),
      .mask_o       (ctl_mask),
      .rd_o         (ctl_rd)
   );

   fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk       (clk),
      .we_i      (wr_fire),
      .lane_we_i (lane_we),
      .waddr_i   (next_addr),
      .wdata_i   (wdata_i),
      .raddr_i   (cur_addr),
      .rdata_o   (arr_rdata)
   );

   // asynchronous output gate: enable, sleep, selected read, first-cycle mask
   assign rdata_en_o = !oe_n && !sleep_i && ctl_active && ctl_rd && !ctl_mask;
   assign rdata_o    = rdata_en_o ? arr_rdata : '0;
endmodule

// File: rtl/fts_burst_sram_chk.sv
`timescale 1ns/1ps
module fts_burst_sram_chk
   import fts_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 36
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cs1_n,
   input logic              cs2,
   input logic              cs3_n,
   input logic              strobe_cpu_n,
   input logic              strobe_ctl_n,
   input logic              adv_n,
   input logic              oe_n,
   input logic              sleep_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              rdata_en_o,
   input logic              ctl_active,
   input beat_t             burst_cnt,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              wr_fire
);
   logic cpu_go, any_go, all_sel;
   assign cpu_go  = !strobe_cpu_n && !cs1_n;
   assign any_go  = cpu_go || !strobe_ctl_n;
   assign all_sel = !cs1_n && cs2 && !cs3_n;

   a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || sleep_i) |-> (!rdata_en_o && rdata_o == '0));

   a_r12_first_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_active) |-> !rdata_en_o);

   a_r13_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> ($stable(cur_addr) && $stable(ctl_active)));

   a_r13_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !wr_fire);

   a_r2_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_go |-> !wr_fire);

   a_r7_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_go && ctl_active && !adv_n && !sleep_i)
         |=> (burst_cnt == $past(burst_cnt) + beat_t'(1)));

   a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (any_go && !all_sel && !sleep_i) |=> (!ctl_active && !rdata_en_o));

   a_r3_ce_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_go && ctl_active) |=> ctl_active);
endmodule

bind fts_burst_sram fts_burst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs1_n        (cs1_n),
   .cs2          (cs2),
   .cs3_n        (cs3_n),
   .strobe_cpu_n (strobe_cpu_n),
   .strobe_ctl_n (strobe_ctl_n),
   .adv_n        (adv_n),
   .oe_n         (oe_n),
   .sleep_i      (sleep_i),
   .rdata_o      (rdata_o),
   .rdata_en_o   (rdata_en_o),
   .ctl_active   (ctl_active),
   .burst_cnt    (burst_cnt),
   .cur_addr     (cur_addr),
   .wr_fire      (wr_fire)
);

// File: tb/fts_burst_sram_bench.sv
`timescale 1ns/1ps
module fts_burst_sram_bench;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i;
   logic          cs1_n, cs2, cs3_n, strobe_cpu_n, strobe_ctl_n, adv_n;
   logic          gwr_n, bwr_n, oe_n, order_il, sleep_i;
   logic [NL-1:0] lane_sel_n;
   logic [DW-1:0] wdata_i, rdata_o;
   logic          rdata_en_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // reference state
   logic [DW-1:0] m_mem [NW];
   logic [AW-1:0] m_base;
   logic [1:0]    m_cnt;
   logic          m_act, m_mask, m_rd;
   bit            g_exp_valid = 1'b0;
   logic [DW-1:0] g_exp_word;

   always #2.5 clk = ~clk;

   fts_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_fts_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
      .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_sel_n(lane_sel_n),
      .oe_n(oe_n), .order_il(order_il), .sleep_i(sleep_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .rdata_en_o(rdata_en_o)
   );

   function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] c, logic il);
      logic [1:0] lo;
      lo = il ? (b[1:0] ^ c) : (b[1:0] + c);
      return {b[AW-1:2], lo};
   endfunction

   function automatic logic [NL-1:0] lanes_of(logic g, logic bw, logic [NL-1:0] s);
      if (!g) return '1;          // R8
      if (!bw) return ~s;         // R9
      return '0;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_edge();
      logic cpu, ctl, st, sel, nact, wr;
      logic [AW-1:0] nbase, na;
      logic [1:0] ncnt;
      logic [NL-1:0] ln;
      if (sleep_i) return;        // R13: nothing moves
      cpu = !strobe_cpu_n && !cs1_n;
      ctl = !strobe_ctl_n && !cpu;
      st  = cpu || ctl;
      sel = !cs1_n && cs2 && !cs3_n;
      nact = m_act; nbase = m_base; ncnt = m_cnt;
      if (st) begin
         nact = sel;
         if (sel) begin nbase = addr_i; ncnt = 2'd0; end
      end else if (m_act && !adv_n) begin
         ncnt = m_cnt + 2'd1;
      end
      ln = lanes_of(gwr_n, bwr_n, lane_sel_n);
      wr = nact && !cpu && (ln != '0);
      na = beat_addr(nbase, ncnt, order_il);
      if (wr)
         for (int l = 0; l < NL; l++)
            if (ln[l]) m_mem[na][l*LW +: LW] = wdata_i[l*LW +: LW];
      m_mask = st && sel && !m_act;
      m_rd   = nact && !wr;
      m_act  = nact; m_base = nbase; m_cnt = ncnt;
   endtask

   task automatic step(input string tag, input int exp_addr = -1, input bit exp_off = 1'b0);
      logic en_e;
      logic [DW-1:0] d_e;
      #1;
      en_e = !oe_n && !sleep_i && m_act && m_rd && !m_mask;
      d_e  = en_e ? m_mem[beat_addr(m_base, m_cnt, order_il)] : '0;
      chk(tag, "enable", DW'(rdata_en_o), DW'(en_e));
      chk(tag, "data", rdata_o, d_e);
      if (exp_addr >= 0) begin
         chk(tag, "explicit enable", DW'(rdata_en_o), DW'(1));
         chk(tag, "explicit word", rdata_o, m_mem[exp_addr]);
      end
      if (exp_off) begin
         chk(tag, "disabled enable", DW'(rdata_en_o), DW'(0));
         chk(tag, "disabled data", rdata_o, '0);
      end
      if (g_exp_valid) begin
         chk(tag, "computed word", rdata_o, g_exp_word);
         g_exp_valid = 1'b0;
      end
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic idle();
      addr_i = '0; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
      strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
      gwr_n = 1'b1; bwr_n = 1'b1; lane_sel_n = '1; oe_n = 1'b0;
      sleep_i = 1'b0; wdata_i = '0;
   endtask

   task automatic run_burst(input string tag, input logic [AW-1:0] base,
                            input int a1, input int a2, input int a3);
      idle(); strobe_ctl_n = 1'b0; addr_i = base; step("R1");
      idle(); adv_n = 1'b0; step("R1", base);
      idle(); adv_n = 1'b0; step(tag, a1);
      idle(); adv_n = 1'b0; step(tag, a2);
      idle(); adv_n = 1'b0; step(tag, a3);
      idle(); step(tag, base);                // wrapped back to the base
      idle(); step("R7", base);
   endtask

   initial begin
      logic [DW-1:0] old_w, new_w;
      void'($urandom(32'h5EED_0C1A));
      order_il = 1'b1;
      idle();
      m_act = 1'b0; m_mask = 1'b0; m_rd = 1'b0; m_base = '0; m_cnt = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // reset state: deselected, output off (R4)
      idle(); step("R4", -1, 1'b1);

      // preload every word with global writes that ignore the byte controls (R8)
      for (int a = 0; a < NW; a++) begin
         idle(); strobe_ctl_n = 1'b0; addr_i = AW'(a); gwr_n = 1'b0;
         bwr_n = 1'b1; lane_sel_n = NL'($urandom); wdata_i = DW'({$urandom, $urandom});
         step("R8");
      end
      idle(); step("R10", -1, 1'b1);          // previous edge wrote: output off
      idle(); step("R10", NW - 1);

      // deselect, then a masked first read (R4, R12)
      idle(); strobe_ctl_n = 1'b0; cs2 = 1'b0; step("R4");
      idle(); step("R4", -1, 1'b1);
      idle(); strobe_ctl_n = 1'b0; addr_i = 6'd9; step("R4", -1, 1'b1);
      idle(); step("R12", -1, 1'b1);
      idle(); step("R7", 9);

      // linear then interleaved beat order from base 9 (low bits 01)
      order_il = 1'b0; run_burst("R5", 6'd9, 10, 11, 8);
      order_il = 1'b1; run_burst("R6", 6'd9, 8, 11, 10);

      // both strobes with write request: processor wins, no write (R2)
      idle(); strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b0; addr_i = 6'd20;
      gwr_n = 1'b0; wdata_i = '1; g_exp_valid = 1'b0; step("R2");
      idle(); step("R2", 20);
      // processor strobe with enable 1 off is not a start (R2)
      idle(); strobe_cpu_n = 1'b0; cs1_n = 1'b1; addr_i = 6'd30; step("R2", 20);
      idle(); step("R2", 20);

      // enables 2 and 3 ignored while bursting (R3): 20 -> 21 interleaved
      idle(); cs2 = 1'b0; cs3_n = 1'b1; adv_n = 1'b0; step("R3", 20);
      idle(); step("R3", 21);

      // partial-lane write to 40: lanes 0 and 2 only (R9)
      old_w = m_mem[40];
      idle(); strobe_ctl_n = 1'b0; addr_i = 6'd40; bwr_n = 1'b0;
      lane_sel_n = 4'b1010; wdata_i = 36'hA_BCDE_F123; step("R9");
      new_w = old_w;
      new_w[8:0]   = 9'h123;
      new_w[26:18] = wdata_i[26:18];
      idle(); step("R9", -1, 1'b1);
      idle(); g_exp_valid = 1'b1; g_exp_word = new_w; step("R9", 40);
      // both write enables high: nothing written (R9)
      idle(); strobe_ctl_n = 1'b0; addr_i = 6'd40; lane_sel_n = '0;
      wdata_i = '0; step("R9");
      idle(); g_exp_valid = 1'b1; g_exp_word = new_w; step("R9", 40);
      // global write overrides deasserted lane selects (R8)
      idle(); strobe_ctl_n = 1'b0; addr_i = 6'd40; gwr_n = 1'b0; bwr_n = 1'b0;
      lane_sel_n = '1; wdata_i = 36'h1_2345_6789; step("R8");
      idle(); step("R8", -1, 1'b1);
      idle(); g_exp_valid = 1'b1; g_exp_word = 36'h1_2345_6789; step("R8", 40);

      // asynchronous output enable (R11)
      idle(); oe_n = 1'b1; step("R11", -1, 1'b1);
      idle(); step("R11", 40);

      // sleep blocks a write attempt and freezes state (R13)
      old_w = m_mem[50];
      idle(); sleep_i = 1'b1; strobe_ctl_n = 1'b0; addr_i = 6'd50;
      gwr_n = 1'b0; wdata_i = '1; step("R13", -1, 1'b1);
      idle(); sleep_i = 1'b1; adv_n = 1'b0; step("R13", -1, 1'b1);
      idle(); step("R13", 40);
      idle(); strobe_ctl_n = 1'b0; addr_i = 6'd50; step("R13");
      idle(); g_exp_valid = 1'b1; g_exp_word = old_w; step("R13", 50);

      // constrained random traffic against the reference (R10 and all others)
      for (int i = 0; i < 4000; i++) begin
         idle();
         if (i == 2000) order_il = 1'b0;
         strobe_cpu_n = ($urandom % 100) >= 10;
         strobe_ctl_n = ($urandom % 100) >= 20;
         cs1_n        = ($urandom % 100) < 8;
         cs2          = ($urandom % 100) >= 8;
         cs3_n        = ($urandom % 100) < 8;
         adv_n        = ($urandom % 100) < 40;
         gwr_n        = ($urandom % 100) >= 12;
         bwr_n        = ($urandom % 100) >= 25;
         lane_sel_n   = NL'($urandom);
         oe_n         = ($urandom % 100) < 10;
         sleep_i      = ($urandom % 100) < 5;
         addr_i       = AW'($urandom);
         wdata_i      = DW'({$urandom, $urandom});
         step("R10");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule